// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block turns 40 external signal lines into interrupt requests for a downstream interrupt controller. The lines are split into a wide bank of 32 and a narrow bank of 8. Each line can be set to fire on a rising edge, a falling edge, both, or neither. A per-line mask gates each line. Software can raise an interrupt by writing a trigger bit. A sticky pending flag records every accepted event until software clears it by writing a one.

Software reaches the block through a simple 32-bit word register bus. Reads are combinational and writes take effect at the clock edge. Four request outputs carry one-clock pulses to the interrupt controller:
- line 0 has its own output.
- line 1 has its own output.
- lines 5 to 9 share one output.
- line 35 (bit 3 of the narrow bank) has its own output.

A request pulse is fired once, when a pending flag goes from 0 to 1. Clearing the flag later does not take back a pulse that was already sent.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every register reads zero and every request output is low. Register word offsets: wide bank at 0x00, narrow bank at 0x20. Inside a bank the offsets are mask +0x00, event mask +0x04, rise select +0x08, fall select +0x0C, soft trigger +0x10, pending +0x14. A read of any other offset returns zero, and a write to one changes nothing.
- R2: In the wide bank, mask and event mask keep all 32 bits. Rise select, fall select, soft trigger and pending keep only the bits in 0x007DFFFF. The other bits read zero.
- R3: In the narrow bank, mask and event mask keep only the bits in 0xFF. Rise select, fall select, soft trigger and pending keep only the bits in 0x78. The other bits read zero.
- R4: Edge detection compares each line with the value sampled at the previous clock edge. A rising edge sets the line's pending bit only if its rise select bit is 1. A falling edge sets it only if its fall select bit is 1. With both select bits set, either edge sets it; with neither, no edge does. The pending bit reads 1 after the clock edge that first samples the new level.
- R5: An enabled edge that arrives while the line's mask bit is 0 is dropped. Setting the mask bit later, with the line still at its new level, leaves the pending bit at 0.
- R6: A write to the soft trigger register stores the written bits. If this write moves a trigger bit from 0 to 1 while the line's mask bit is 1, the pending bit is set at that same clock edge.
- R7: A soft trigger bit written to 1 while its line is masked reads back 1, but the pending bit stays 0. Unmasking the line afterwards still leaves the pending bit at 0.
- R8: Writing 1 to a pending bit clears that bit and the matching soft trigger bit. Writing 0 has no effect. If a new event for a line arrives in the same cycle as a clear of that line, the pending bit stays 1.
- R9: Each request output is a one-clock pulse. It goes high in the cycle in which one of its lines' pending bits first reads 1. The outputs are:
  - irq_req[0]: line 0.
  - irq_req[1]: line 1.
  - irq_req[2]: any of lines 5 to 9.
  - irq_req[3]: line 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when not reading a mapped register |
| line_in | input | 40 | External lines, synchronous to clk; bits 39:32 are the narrow bank |
| irq_req | output | 4 | Request pulses to the interrupt controller |

## Verification
Directed cases drive a single line through the four edge selections. These cases separate rise-only, fall-only, both-edge and no-edge behaviour, and they show whether the history register is compared in the right direction. Mask-ordering cases raise an edge or a soft trigger first and unmask afterwards, which shows whether events are wrongly remembered. Separate cases clear a pending bit in the same cycle as a new edge, and toggle lines 5 to 9 one after another, to check the clear-versus-set priority and the shared-output routing. A seeded random phase then mixes sparse line toggles with writes and reads to any address, mapped or not, against a bench model. This exposes writability mask errors and interactions between the registers that the directed cases do not reach.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int unsigned DATA_W = 32;

   // register index inside a bank (address bits 4:2)
   localparam logic [2:0] RS_MASK = 3'd0;
   localparam logic [2:0] RS_EVT  = 3'd1;
   localparam logic [2:0] RS_RISE = 3'd2;
   localparam logic [2:0] RS_FALL = 3'd3;
   localparam logic [2:0] RS_SWT  = 3'd4;
   localparam logic [2:0] RS_PEND = 3'd5;
endpackage

// File: rtl/xirq_edge.sv
module xirq_edge #(
   parameter int unsigned LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_in,
   output logic [LINES-1:0] rise,
   output logic [LINES-1:0] fall
);
   logic [LINES-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= line_in;
   end

   assign rise = line_in & ~hist_q;
   assign fall = ~line_in & hist_q;
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
   import xirq_pkg::*;
#(
   parameter int unsigned        LINES     = 32,
   parameter logic [DATA_W-1:0]  KEEP_MASK = '1,
   parameter logic [DATA_W-1:0]  KEEP_TRIG = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LINES-1:0]  line_in,
   output logic [DATA_W-1:0] rdata,
   output logic [LINES-1:0]  set_pulse,
   output logic [LINES-1:0]  pend_o,
   output logic [LINES-1:0]  mask_o,
   output logic [LINES-1:0]  swt_o
);
   if (LINES == 0 || LINES > DATA_W) begin : g_bad_lines
      $error("xirq_bank: LINES must be 1..DATA_W");
   end
   if (LINES < DATA_W) begin : g_chk_keep
      if ((KEEP_MASK >> LINES) != '0 || (KEEP_TRIG >> LINES) != '0) begin : g_bad_keep
         $error("xirq_bank: keep masks exceed LINES");
      end
   end

   localparam logic [LINES-1:0] KM = KEEP_MASK[LINES-1:0];
   localparam logic [LINES-1:0] KT = KEEP_TRIG[LINES-1:0];

   logic [LINES-1:0] mask_q, evt_q, rise_q, fall_q, swt_q, pend_q, pulse_q;
   logic [LINES-1:0] rise, fall, wd, hw_hit, sw_hit, clr, pend_d;
   logic             unused_wdata;

   xirq_edge #(.LINES(LINES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .rise    (rise),
      .fall    (fall)
   );

   assign wd           = wdata[LINES-1:0];
   assign unused_wdata = ^wdata;

   assign hw_hit = mask_q & ((rise_q & rise) | (fall_q & fall));
   assign sw_hit = (wr_en && reg_sel == RS_SWT) ? (mask_q & wd & KT & ~swt_q) : '0;
   assign clr    = (wr_en && reg_sel == RS_PEND) ? (wd & KT) : '0;
   assign pend_d = (pend_q & ~clr) | hw_hit | sw_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         evt_q   <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
         swt_q   <= '0;
         pend_q  <= '0;
         pulse_q <= '0;
      end else begin
         pend_q  <= pend_d;
         pulse_q <= pend_d & ~pend_q;
         if (wr_en) begin
            case (reg_sel)
               RS_MASK: mask_q <= wd & KM;
               RS_EVT:  evt_q  <= wd & KM;
               RS_RISE: rise_q <= wd & KT;
               RS_FALL: fall_q <= wd & KT;
               RS_SWT:  swt_q  <= wd & KT;
               RS_PEND: swt_q  <= swt_q & ~clr;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_sel)
         RS_MASK: rdata = DATA_W'(mask_q);
         RS_EVT:  rdata = DATA_W'(evt_q);
         RS_RISE: rdata = DATA_W'(rise_q);
         RS_FALL: rdata = DATA_W'(fall_q);
         RS_SWT:  rdata = DATA_W'(swt_q);
         RS_PEND: rdata = DATA_W'(pend_q);
         default: rdata = '0;
      endcase
   end

   assign set_pulse = pulse_q;
   assign pend_o    = pend_q;
   assign mask_o    = mask_q;
   assign swt_o     = swt_q;
endmodule

// File: rtl/xirq_route.sv
module xirq_route #(
   parameter int unsigned L0     = 32,
   parameter int unsigned L1     = 8,
   parameter int unsigned SOLO_A = 0,
   parameter int unsigned SOLO_B = 1,
   parameter int unsigned GRP_LO = 5,
   parameter int unsigned GRP_HI = 9,
   parameter int unsigned SOLO_C = 3
) (
   input  logic [L0-1:0] set0,
   input  logic [L1-1:0] set1,
   output logic [3:0]    irq
);
   if (SOLO_A >= L0 || SOLO_B >= L0 || GRP_HI >= L0 || GRP_LO > GRP_HI) begin : g_bad_w
      $error("xirq_route: wide bank routing out of range");
   end
   if (SOLO_C >= L1) begin : g_bad_n
      $error("xirq_route: narrow bank routing out of range");
   end

   logic [L0-1:0] in_grp;
   logic          unused_set;

   for (genvar g = 0; g < L0; g++) begin : g_grp
      if (g >= GRP_LO && g <= GRP_HI) begin : g_in
         assign in_grp[g] = set0[g];
      end else begin : g_out
         assign in_grp[g] = 1'b0;
      end
   end

   assign irq[0]     = set0[SOLO_A];
   assign irq[1]     = set0[SOLO_B];
   assign irq[2]     = |in_grp;
   assign irq[3]     = set1[SOLO_C];
   assign unused_set = ^{set0, set1};
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 8,
   parameter int unsigned       L0      = 32,
   parameter int unsigned       L1      = 8,
   parameter logic [DATA_W-1:0] K0_MASK = 32'hFFFF_FFFF,
   parameter logic [DATA_W-1:0] K0_TRIG = 32'h007D_FFFF,
   parameter logic [DATA_W-1:0] K1_MASK = 32'h0000_00FF,
   parameter logic [DATA_W-1:0] K1_TRIG = 32'h0000_0078
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [L0+L1-1:0]  line_in,
   output logic [3:0]        irq_req
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("xirq_ctrl: ADDR_W must be at least 6");
   end

   localparam int unsigned NL = L0 + L1;

   logic              hi_ok, reg_ok, map_ok, bank_sel, wr0, wr1, unused_misc;
   logic [2:0]        reg_sel;
   logic [DATA_W-1:0] rd0, rd1;
   logic [L0-1:0]     set_b0, pend_b0, mask_b0, swt_b0;
   logic [L1-1:0]     set_b1, pend_b1, mask_b1, swt_b1;

   assign hi_ok    = (bus_addr >> 6) == '0;
   assign bank_sel = bus_addr[5];
   assign reg_sel  = bus_addr[4:2];
   assign reg_ok   = reg_sel <= RS_PEND;
   assign map_ok   = hi_ok && reg_ok;
   assign wr0      = bus_en && bus_we && map_ok && !bank_sel;
   assign wr1      = bus_en && bus_we && map_ok && bank_sel;

   xirq_bank #(.LINES(L0), .KEEP_MASK(K0_MASK), .KEEP_TRIG(K0_TRIG)) u_bank0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr0),
      .reg_sel   (reg_sel),
      .wdata     (bus_wdata),
      .line_in   (line_in[L0-1:0]),
      .rdata     (rd0),
      .set_pulse (set_b0),
      .pend_o    (pend_b0),
      .mask_o    (mask_b0),
      .swt_o     (swt_b0)
   );

   xirq_bank #(.LINES(L1), .KEEP_MASK(K1_MASK), .KEEP_TRIG(K1_TRIG)) u_bank1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr1),
      .reg_sel   (reg_sel),
      .wdata     (bus_wdata),
      .line_in   (line_in[NL-1:L0]),
      .rdata     (rd1),
      .set_pulse (set_b1),
      .pend_o    (pend_b1),
      .mask_o    (mask_b1),
      .swt_o     (swt_b1)
   );

   xirq_route #(.L0(L0), .L1(L1)) u_route (
      .set0 (set_b0),
      .set1 (set_b1),
      .irq  (irq_req)
   );

   assign bus_rdata   = (bus_en && !bus_we && map_ok) ? (bank_sel ? rd1 : rd0) : '0;
   assign unused_misc = ^{bus_addr[1:0], pend_b1, mask_b1, swt_b1, mask_b0, swt_b0, pend_b0};
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned L0     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [3:0]        irq_req,
   input logic [L0-1:0]     pend0,
   input logic [L0-1:0]     mask0,
   input logic [L0-1:0]     swt0
);
   localparam logic [ADDR_W-1:0] OFS_PEND0 = ADDR_W'(8'h14);
   localparam logic [ADDR_W-1:0] OFS_PEND1 = ADDR_W'(8'h34);

   // R5/R7: a pending bit can only rise on a line that was unmasked
   a_r5_pend_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend0 & ~$past(pend0) & ~$past(mask0)) == '0));

   // R9: dedicated outputs are single-cycle pulses
   a_r9_pulse_line0: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[0] |=> !irq_req[0]);
   a_r9_pulse_line1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[1] |=> !irq_req[1]);

   // R9: a request pulse coincides with its pending bit reading 1
   a_r9_req_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[0] |-> pend0[0]);
   a_r9_grp_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[2] |-> (|pend0[9:5]));

   // R8: clearing a pending bit also clears the soft trigger bit
   a_r8_clear_swt: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == OFS_PEND0 && bus_wdata[0]) |=> !swt0[0]);

   // R3: narrow-bank pending reads zero outside 0x78
   a_r3_pend1_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == OFS_PEND1) |-> ((bus_rdata & ~32'h78) == '0));
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.ADDR_W(ADDR_W), .L0(L0)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_req   (irq_req),
   .pend0     (pend_b0),
   .mask0     (mask_b0),
   .swt0      (swt_b0)
);

// File: tb/test_xirq_ctrl.sv
`timescale 1ns/1ps
module test_xirq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [39:0] line_in = '0;
   logic [3:0]  irq_req;

   int total = 0, bad = 0;
   logic [39:0] cur_lines = '0;
   logic [3:0]  exp_irq = '0, last_irq = '0;
   logic [31:0] m_reg [0:1][0:5];
   logic [31:0] m_inq [0:1];

   always #2 clk = ~clk;

   xirq_ctrl i_xirq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_in(line_in), .irq_req(irq_req)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] keep(input int b, input int i);
      if (b == 0) return (i <= 1) ? 32'hFFFF_FFFF : 32'h007D_FFFF;
      return (i <= 1) ? 32'h0000_00FF : 32'h0000_0078;
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a[7:6] != 2'b00 || a[4:2] > 3'd5) return 32'h0;
      return m_reg[int'(a[5])][int'(a[4:2])];
   endfunction

   task automatic model_step(input logic en, input logic we, input logic [7:0] a,
                             input logic [31:0] d, input logic [39:0] ln);
      logic [31:0] pulse [0:1];
      logic [31:0] inv, hit, swh, clr, nxt;
      bit ok;
      int i;
      ok = (a[7:6] == 2'b00) && (a[4:2] <= 3'd5);
      for (int b = 0; b < 2; b++) begin
         inv = (b == 0) ? ln[31:0] : {24'b0, ln[39:32]};
         hit = m_reg[b][0] & ((m_reg[b][2] & inv & ~m_inq[b]) | (m_reg[b][3] & ~inv & m_inq[b]));
         swh = '0;
         clr = '0;
         if (en && we && ok && int'(a[5]) == b) begin
            i = int'(a[4:2]);
            if (i == 4) begin
               swh = m_reg[b][0] & d & keep(b, 4) & ~m_reg[b][4];
               m_reg[b][4] = d & keep(b, 4);
            end else if (i == 5) begin
               clr = d & keep(b, 5);
            end else begin
               m_reg[b][i] = d & keep(b, i);
            end
         end
         nxt = (m_reg[b][5] & ~clr) | hit | swh;
         pulse[b] = nxt & ~m_reg[b][5];
         m_reg[b][4] = m_reg[b][4] & ~clr;
         m_reg[b][5] = nxt;
         m_inq[b] = inv;
      end
      exp_irq = {pulse[1][3], |pulse[0][9:5], pulse[0][1], pulse[0][0]};
   endtask

   // one bus cycle; called right after a falling edge
   task automatic tick(input logic en, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input string tag);
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; line_in = cur_lines;
      #1;
      if (en && !we) chk(tag, bus_rdata, model_read(a));
      model_step(en, we, a, d, cur_lines);
      @(posedge clk);
      @(negedge clk);
      last_irq = irq_req;
      chk("R9", {28'b0, irq_req}, {28'b0, exp_irq});
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      tick(1'b1, 1'b1, a, d, "R1");
   endtask

   task automatic idle();
      tick(1'b0, 1'b0, 8'h00, 32'h0, "R1");
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; line_in = cur_lines;
      #1;
      chk(tag, bus_rdata, exp);
      tick(1'b1, 1'b0, a, 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] rv;
      void'($urandom(32'd4021));
      for (int b = 0; b < 2; b++) begin
         m_inq[b] = '0;
         for (int i = 0; i < 6; i++) m_reg[b][i] = '0;
      end
      repeat (3) @(negedge clk);
      chk("R1", {28'b0, irq_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state and unmapped offsets
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 6; i++) rd_exp(8'(b * 32 + i * 4), 32'h0, "R1");
      wr(8'h18, 32'hFFFF_FFFF);
      rd_exp(8'h18, 32'h0, "R1");
      wr(8'h48, 32'hFFFF_FFFF);
      rd_exp(8'h48, 32'h0, "R1");

      // R2: wide bank writability
      wr(8'h08, 32'hFFFF_FFFF); rd_exp(8'h08, 32'h007D_FFFF, "R2");
      wr(8'h04, 32'hFFFF_FFFF); rd_exp(8'h04, 32'hFFFF_FFFF, "R2");
      wr(8'h10, 32'hFF82_0000); rd_exp(8'h10, 32'h0, "R2");
      wr(8'h08, 32'h0); wr(8'h04, 32'h0);

      // R3: narrow bank writability
      wr(8'h20, 32'hFFFF_FFFF); rd_exp(8'h20, 32'h0000_00FF, "R3");
      wr(8'h2C, 32'hFFFF_FFFF); rd_exp(8'h2C, 32'h0000_0078, "R3");
      wr(8'h2C, 32'h0); wr(8'h20, 32'h0);
      wr(8'h30, 32'hFFFF_FF87); rd_exp(8'h30, 32'h0, "R3");

      // R4: rise only
      wr(8'h00, 32'h1); wr(8'h08, 32'h1); wr(8'h0C, 32'h0);
      cur_lines[0] = 1'b1; idle();
      chk("R4", {28'b0, last_irq}, 32'h1);
      rd_exp(8'h14, 32'h1, "R4");
      wr(8'h14, 32'h1); rd_exp(8'h14, 32'h0, "R8");
      cur_lines[0] = 1'b0; idle(); rd_exp(8'h14, 32'h0, "R4");
      // R4: fall only
      wr(8'h08, 32'h0); wr(8'h0C, 32'h1);
      cur_lines[0] = 1'b1; idle(); rd_exp(8'h14, 32'h0, "R4");
      cur_lines[0] = 1'b0; idle(); rd_exp(8'h14, 32'h1, "R4");
      wr(8'h14, 32'h1);
      // R4: both edges
      wr(8'h08, 32'h1);
      cur_lines[0] = 1'b1; idle(); rd_exp(8'h14, 32'h1, "R4"); wr(8'h14, 32'h1);
      cur_lines[0] = 1'b0; idle(); rd_exp(8'h14, 32'h1, "R4"); wr(8'h14, 32'h1);
      // R4: no edge selected
      wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
      cur_lines[0] = 1'b1; idle(); rd_exp(8'h14, 32'h0, "R4");
      cur_lines[0] = 1'b0; idle(); rd_exp(8'h14, 32'h0, "R4");

      // R5: masked edge is not remembered
      wr(8'h00, 32'h0); wr(8'h08, 32'h2);
      cur_lines[1] = 1'b1; idle(); rd_exp(8'h14, 32'h0, "R5");
      wr(8'h00, 32'h2); idle(); rd_exp(8'h14, 32'h0, "R5");
      cur_lines[1] = 1'b0; idle();

      // R6: soft trigger, wide bank line 0 and narrow bank line 35
      wr(8'h00, 32'h1); wr(8'h10, 32'h0); wr(8'h10, 32'h1);
      chk("R6", {28'b0, last_irq}, 32'h1);
      rd_exp(8'h10, 32'h1, "R6"); rd_exp(8'h14, 32'h1, "R6");
      wr(8'h10, 32'h1); rd_exp(8'h14, 32'h1, "R6");
      wr(8'h14, 32'h1); rd_exp(8'h10, 32'h0, "R8"); rd_exp(8'h14, 32'h0, "R8");
      wr(8'h20, 32'h8); wr(8'h30, 32'h0); wr(8'h30, 32'h8);
      chk("R6", {28'b0, last_irq}, 32'h8);
      rd_exp(8'h34, 32'h8, "R6");
      wr(8'h34, 32'h8); rd_exp(8'h30, 32'h0, "R8"); rd_exp(8'h34, 32'h0, "R8");

      // R7: soft trigger while masked
      wr(8'h00, 32'h0); wr(8'h10, 32'h0); wr(8'h10, 32'h1);
      rd_exp(8'h10, 32'h1, "R7"); rd_exp(8'h14, 32'h0, "R7");
      wr(8'h00, 32'h1); rd_exp(8'h14, 32'h0, "R7");
      wr(8'h10, 32'h0);

      // R8: write 0 has no effect, set wins over clear
      wr(8'h10, 32'h1); wr(8'h14, 32'h0); rd_exp(8'h14, 32'h1, "R8");
      wr(8'h00, 32'h3); wr(8'h08, 32'h2);
      cur_lines[1] = 1'b1; wr(8'h14, 32'h3); rd_exp(8'h14, 32'h2, "R8");
      wr(8'h14, 32'h2); cur_lines[1] = 1'b0; idle(); wr(8'h10, 32'h0);

      // R9: lines 5..9 share one request, each sets only its own bit
      wr(8'h00, 32'h3E0); wr(8'h08, 32'h3E0); wr(8'h0C, 32'h0);
      for (int i = 5; i < 10; i++) begin
         cur_lines[i] = 1'b1; idle();
         chk("R9", {28'b0, last_irq}, 32'h4);
         rd_exp(8'h14, 32'h1 << i, "R9");
         wr(8'h14, 32'h1 << i);
         cur_lines[i] = 1'b0; idle();
      end
      // R9: line 35 from hardware
      wr(8'h20, 32'h8); wr(8'h28, 32'h8);
      cur_lines[35] = 1'b1; idle();
      chk("R9", {28'b0, last_irq}, 32'h8);
      wr(8'h34, 32'h8);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         int op, b, i;
         rv = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} &
              {$urandom, $urandom};
         cur_lines = cur_lines ^ rv[39:0];
         op = int'($urandom % 8);
         b = int'($urandom % 2);
         i = int'($urandom % 6);
         case (op)
            3, 4:    wr(8'(b * 32 + i * 4), $urandom | $urandom);
            5:       tick(1'b1, 1'b0, 8'($urandom), 32'h0, "R1");
            6:       tick(1'b1, 1'b0, 8'(b * 32 + i * 4), 32'h0, "R2");
            7:       wr(8'($urandom), $urandom);
            default: idle();
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule